// File: doc/BRIEF.md
# Ring Producer with Wrap Counter

This block places incoming entries into a circular ring of power-of-two depth and labels each one with a fixed ring identifier and a 4-bit pass number. The pass number tells how many times the producer has gone around the ring. A consumer-side checker inside the block compares the lowest bit of that pass number against the value it expects for its own current pass. This tells it whether the slot under its read index holds a fresh entry, without consulting the producer's write position.

Entries arrive on a valid/ready input. Every accepted entry also appears on a memory-style write port, so it can be mirrored into external storage. The consumer sees the slot at its read index and a `rd_new` flag, and frees the slot by pulsing `rd_take`. The producer holds `in_ready` low while every slot is still waiting to be freed.

Top module: `ring_wrap_producer`

## Requirements
- R1: After reset `in_ready` is 1, `rd_new` is 0, `rd_idx` is 0, and every slot reads as all zeros. That means pass number 0 and ring identifier 0, the idle ring.
- R2: A written word has the pass number in bits [31:28], the ring identifier (parameter `RING_ID`, nonzero) in bits [27:20] and the payload in bits [19:0].
- R3: `wr_en` is 1 exactly in the cycles where `in_valid` and `in_ready` are both 1. `wr_addr` steps through 0 to DEPTH-1 and then returns to 0.
- R4: Entries written on the first pass carry pass number 1. The number increases by one each time the write address wraps from DEPTH-1 to 0.
- R5: After a pass numbered 15, the next pass is numbered 0.
- R6: When DEPTH entries are unreleased, `in_ready` is 0. An `in_valid` in that state writes nothing and leaves the stored slots unchanged.
- R7: `rd_new` is 1 exactly when the slot at `rd_idx` has a pass-number LSB equal to the consumer's expected LSB. The expected LSB starts at 1 and toggles each time `rd_idx` wraps from DEPTH-1 to 0.
- R8: A `rd_take` while `rd_new` is 0 has no effect: `rd_idx` and `in_ready` are unchanged.
- R9: A `rd_take` while `rd_new` is 1 advances `rd_idx` by one (modulo DEPTH) and frees the slot. If `in_ready` was 0, it returns to 1 on the next cycle.
- R10: `rd_entry` shows the word most recently written to the slot at `rd_idx`, from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Entry offered |
| in_ready | output | 1 | A free slot exists |
| in_payload | input | 20 | Entry payload |
| wr_en | output | 1 | Write strobe of the storage port |
| wr_addr | output | clog2(DEPTH) | Slot being written |
| wr_data | output | 32 | Stamped word being written |
| rd_idx | output | clog2(DEPTH) | Consumer read index |
| rd_entry | output | 32 | Word held in slot `rd_idx` |
| rd_new | output | 1 | Slot `rd_idx` holds a fresh entry |
| rd_take | input | 1 | Consumer frees slot `rd_idx` |

## Verification
A corrupted pass register shows up on `wr_data[31:28]` at the next accepted write. Within one pass it also turns `rd_new` low on a slot the consumer should accept, so the stream stalls at that slot. A wrong occupancy count or a wrong expected-LSB register breaks the agreement between `in_ready` and `rd_new` within one cycle: a full ring with no fresh entry, or a fresh flag on an empty ring. A long stream of sixteen and more passes, with freshness checked at every slot, exposes rollover and toggle faults at the wrap where they occur.

// File: rtl/rwp_pkg.sv
package rwp_pkg;
   localparam int PASS_W = 4;
   localparam int RID_W  = 8;
   localparam int PAY_W  = 20;
   localparam int WORD_W = PASS_W + RID_W + PAY_W;

   // field order is the word layout: pass [31:28], ring [27:20], payload [19:0]
   typedef struct packed {
      logic [PASS_W-1:0] pass;
      logic [RID_W-1:0]  ring;
      logic [PAY_W-1:0]  pay;
   } slot_word_t;

   localparam slot_word_t IDLE_WORD = '0;
endpackage

// File: rtl/rwp_producer.sv
module rwp_producer
   import rwp_pkg::*;
#(
   parameter int DEPTH   = 8,
   parameter int RING_ID = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [PAY_W-1:0]         in_payload,
   input  logic                     slot_free,
   output logic                     in_ready,
   output logic                     wr_en,
   output logic [$clog2(DEPTH)-1:0] wr_addr,
   output slot_word_t               wr_word,
   output logic [$clog2(DEPTH):0]   fill
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);
   localparam logic [AW:0]   FULL_FILL = (AW+1)'(DEPTH);
   localparam logic [PASS_W-1:0] FIRST_PASS = PASS_W'(1);

   logic [AW-1:0]     widx_q;
   logic [PASS_W-1:0] pass_q;
   logic [AW:0]       fill_q;

   assign in_ready = (fill_q != FULL_FILL);
   assign wr_en    = in_valid & in_ready;
   assign wr_addr  = widx_q;
   assign fill     = fill_q;

   always_comb begin
      wr_word      = IDLE_WORD;
      wr_word.pass = pass_q;
      wr_word.ring = RID_W'(RING_ID);
      wr_word.pay  = in_payload;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         widx_q <= '0;
         pass_q <= FIRST_PASS;
      end else if (wr_en) begin
         widx_q <= widx_q + 1'b1;
         if (widx_q == LAST_SLOT) pass_q <= pass_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) fill_q <= '0;
      else begin
         case ({wr_en, slot_free})
            2'b10:   fill_q <= fill_q + 1'b1;
            2'b01:   fill_q <= fill_q - 1'b1;
            default: fill_q <= fill_q;
         endcase
      end
   end

   AST_PASS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && widx_q == LAST_SLOT) |=> pass_q == $past(pass_q) + 1'b1); // R4
   AST_PASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && widx_q != LAST_SLOT) |=> $stable(pass_q)); // R4
   AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      fill_q <= FULL_FILL); // R6
endmodule

// File: rtl/rwp_store.sv
module rwp_store
   import rwp_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [$clog2(DEPTH)-1:0] wr_addr,
   input  slot_word_t               wr_word,
   input  logic [$clog2(DEPTH)-1:0] rd_addr,
   output slot_word_t               rd_word
);
   localparam int AW = $clog2(DEPTH);

   slot_word_t slot_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) slot_q[g] <= IDLE_WORD;
         else if (wr_en && wr_addr == AW'(g)) slot_q[g] <= wr_word;
      end
   end

   assign rd_word = slot_q[rd_addr];

   AST_SLOT_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> slot_q[$past(wr_addr)] == $past(wr_word)); // R10
endmodule

// File: rtl/rwp_consumer.sv
module rwp_consumer
   import rwp_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  slot_word_t               cur_word,
   input  logic                     rd_take,
   output logic [$clog2(DEPTH)-1:0] rd_idx,
   output logic                     rd_new,
   output logic                     slot_free
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

   logic [AW-1:0] ridx_q;
   logic          want_lsb_q;

   assign rd_idx    = ridx_q;
   assign rd_new    = (cur_word.pass[0] == want_lsb_q);
   assign slot_free = rd_take & rd_new;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ridx_q     <= '0;
         want_lsb_q <= 1'b1;
      end else if (slot_free) begin
         ridx_q <= ridx_q + 1'b1;
         if (ridx_q == LAST_SLOT) want_lsb_q <= ~want_lsb_q;
      end
   end

   AST_TAKE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_take && !rd_new) |=> $stable(ridx_q)); // R8
   AST_LSB_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_free && ridx_q == LAST_SLOT) |=> want_lsb_q != $past(want_lsb_q)); // R7
endmodule

// File: rtl/ring_wrap_producer.sv
module ring_wrap_producer
   import rwp_pkg::*;
#(
   parameter int DEPTH   = 8,
   parameter int RING_ID = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   output logic                     in_ready,
   input  logic [19:0]              in_payload,
   output logic                     wr_en,
   output logic [$clog2(DEPTH)-1:0] wr_addr,
   output logic [31:0]              wr_data,
   output logic [$clog2(DEPTH)-1:0] rd_idx,
   output logic [31:0]              rd_entry,
   output logic                     rd_new,
   input  logic                     rd_take
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("ring depth must be a power of two of at least 2");
   end
   if (RING_ID < 1 || RING_ID > 255) begin : g_bad_id
      $error("ring identifier must be 1..255; 0 marks the idle ring");
   end
   if (WORD_W != 32) begin : g_bad_word
      $error("slot word must be 32 bits");
   end

   slot_word_t wr_word, cur_word;
   logic       slot_free;
   logic [AW:0] fill;

   rwp_producer #(.DEPTH(DEPTH), .RING_ID(RING_ID)) prod_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_payload(in_payload),
      .slot_free(slot_free), .in_ready(in_ready), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_word(wr_word), .fill(fill)
   );

   rwp_store #(.DEPTH(DEPTH)) store_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_word(wr_word), .rd_addr(rd_idx), .rd_word(cur_word)
   );

   rwp_consumer #(.DEPTH(DEPTH)) cons_i (
      .clk(clk), .rst_n(rst_n), .cur_word(cur_word), .rd_take(rd_take),
      .rd_idx(rd_idx), .rd_new(rd_new), .slot_free(slot_free)
   );

   assign wr_data  = wr_word;
   assign rd_entry = cur_word;

   AST_NEW_MATCHES_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      rd_new == (fill != '0)); // R7
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |-> rd_new); // R6
endmodule

// File: tb/ring_wrap_producer_tb.sv
module ring_wrap_producer_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 8;
   localparam logic [7:0] RID = 8'd3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic in_ready;
   logic [19:0] in_payload = '0;
   logic wr_en;
   logic [2:0] wr_addr;
   logic [31:0] wr_data;
   logic [2:0] rd_idx;
   logic [31:0] rd_entry;
   logic rd_new;
   logic rd_take = 1'b0;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ring_wrap_producer #(.DEPTH(DEPTH), .RING_ID(3)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_payload(in_payload), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_idx(rd_idx), .rd_entry(rd_entry),
      .rd_new(rd_new), .rd_take(rd_take)
   );

   // vector: valid, take, ready, wr, new, addr[2:0], idx[2:0]
   localparam logic [10:0] VEC [0:5] = '{
      11'b1_0_1_1_0_000_000,
      11'b1_1_1_1_1_001_000,
      11'b0_1_1_0_1_010_001,
      11'b0_1_1_0_0_010_010,
      11'b1_0_1_1_0_010_010,
      11'b0_0_1_0_1_011_010
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0; rd_take = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      #1;
      check("R1 ready", 32'(in_ready), 32'd1);
      check("R1 new", 32'(rd_new), 32'd0);
      check("R1 idx", 32'(rd_idx), 32'd0);
      check("R1 entry", rd_entry, 32'd0);
      // R8: take on empty ring is ignored
      @(negedge clk); rd_take = 1'b1;
      @(negedge clk); rd_take = 1'b0; #1;
      check("R8 idx after ignored take", 32'(rd_idx), 32'd0);
      check("R8 ready after ignored take", 32'(in_ready), 32'd1);

      // table walk: all within the first pass
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         in_valid = VEC[i][10]; rd_take = VEC[i][9];
         in_payload = 20'hA0000 + 20'(i);
         #1;
         check("R6 ready", 32'(in_ready), 32'(VEC[i][8]));
         check("R3 wr_en", 32'(wr_en), 32'(VEC[i][7]));
         check("R7 new", 32'(rd_new), 32'(VEC[i][6]));
         check("R3 addr", 32'(wr_addr), 32'(VEC[i][5:3]));
         check("R9 idx", 32'(rd_idx), 32'(VEC[i][2:0]));
         if (VEC[i][7]) check("R2 word", wr_data, {4'd1, RID, 20'hA0000 + 20'(i)});
      end
      @(negedge clk); in_valid = 1'b0; rd_take = 1'b0;

      // fill the ring to the top
      do_reset();
      for (int i = 0; i < DEPTH; i++) begin
         in_valid = 1'b1; in_payload = 20'h30000 + 20'(i);
         #1 check("R3 fill addr", 32'(wr_addr), 32'(i));
         @(negedge clk);
      end
      in_valid = 1'b1; in_payload = 20'hFFFFF;
      #1;
      check("R6 ready low when full", 32'(in_ready), 32'd0);
      check("R6 no write when full", 32'(wr_en), 32'd0);
      @(negedge clk);
      in_valid = 1'b0; rd_take = 1'b1;
      #1;
      check("R6 slot kept", rd_entry, {4'd1, RID, 20'h30000});
      @(negedge clk); rd_take = 1'b0; #1;
      check("R9 ready back", 32'(in_ready), 32'd1);
      check("R9 idx advanced", 32'(rd_idx), 32'd1);
      check("R10 next slot", rd_entry, {4'd1, RID, 20'h30001});

      // long stream across 17 passes
      do_reset();
      for (int i = 0; i < DEPTH * 17; i++) begin
         in_valid = 1'b1; in_payload = 20'(i * 7 + 5); rd_take = (i > 0);
         #1;
         check("R3 stream wr_en", 32'(wr_en), 32'd1);
         check("R3 stream addr", 32'(wr_addr), 32'(i % DEPTH));
         check("R4 R5 pass stamp", 32'(wr_data[31:20]),
               32'({4'((i / DEPTH + 1) % 16), RID}));
         if (i > 0) begin
            check("R7 fresh", 32'(rd_new), 32'd1);
            check("R10 entry", 32'(rd_entry[19:0]), 32'(20'((i - 1) * 7 + 5)));
            check("R9 stream idx", 32'(rd_idx), 32'((i - 1) % DEPTH));
         end
         @(negedge clk);
      end
      in_valid = 1'b0; rd_take = 1'b1;
      @(negedge clk); rd_take = 1'b0; #1;
      check("R7 stale after drain", 32'(rd_new), 32'd0);
      check("R7 stale slot holds old pass", 32'(rd_entry[31:28]), 32'd1);
      check("R9 idx after drain", 32'(rd_idx), 32'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule